// File: doc/BRIEF.md
# Bus Target Command Register with Parity Error Signalling

This block holds the 16-bit command register of a bus target and the unit that checks even parity on the multiplexed address/data bus. Configuration software writes the register through a one-cycle write strobe and reads it back combinationally. Some bits are ordinary read/write controls. Some are fixed at zero. One bit, the fast back-to-back enable, can be written only while an external board strap allows it.

On every address phase, and on every data phase in which the block acts as target, the 32 address/data lines and the 4 command/byte-enable lines are captured. The parity line is taken on the following clock. If the even parity of all 37 bits fails, the block registers the error. It then emits a one-clock active-low pulse on the data parity error output (data phases) or on the system error output (address phases), each gated by its enable bits. A sticky detected-error flag records every failure, whether or not the enables are set. Software clears it by writing 1.

Top module: `pci_cmd_parity`

## Requirements
- R1: After reset the command read value is 0x0000, both error outputs are high and the sticky flag is 0.
- R2: Bits 0–4, 6 and 8 are read/write. Bits 15–10, 7 (stepping) and 5 (palette snoop) always read 0, and writes to them have no effect.
- R3: Bit 9 (fast back-to-back enable) is written and read back normally while `fbb_strap` is 1. While the strap is 0, bit 9 reads 0 and writes to it are ignored.
- R4: A parity error exists when the XOR of `ad[31:0]`, `cbe[3:0]` (sampled in the phase cycle) and `par` (sampled one clock later) equals 1. Correct parity produces no error indication.
- R5: A data-phase parity error with bit 6 set drives `perr_n` low for exactly one clock, starting at the second rising edge after the phase edge. With bit 6 clear, `perr_n` stays high.
- R6: An address-phase parity error drives `serr_n` low for one clock with the same timing as R5, but only when bits 8 and 6 are both set. An address-phase error never drives `perr_n`, and a data-phase error never drives `serr_n`.
- R7: The sticky flag `par_err_seen` is set at the same edge as the R5/R6 pulse for any parity error, regardless of the enables. Writing `sts_wr` with `sts_wdata`=1 clears it, and `sts_wdata`=0 has no effect. A new error at the clearing edge wins and keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Command register write strobe |
| cfg_wdata | input | 16 | Command register write data |
| cfg_rdata | output | 16 | Command register read value |
| fbb_strap | input | 1 | Strap allowing bit 9 to be written |
| ad | input | 32 | Address/data bus |
| cbe | input | 4 | Command/byte-enable lanes |
| par | input | 1 | Even parity line, valid one clock after its phase |
| addr_phase | input | 1 | Current cycle is an address phase |
| data_phase | input | 1 | Current cycle is a data phase with this block as target |
| perr_n | output | 1 | Active-low data parity error pulse |
| serr_n | output | 1 | Active-low system error pulse |
| sts_wr | input | 1 | Sticky flag write strobe |
| sts_wdata | input | 1 | Sticky flag write data (1 clears) |
| par_err_seen | output | 1 | Sticky detected-parity-error flag |

## Verification
A register write is visible on `cfg_rdata` right after the writing edge. The bench therefore reads it back at the falling edge that follows. For a bus phase at rising edge k, parity is taken at k+1, the error is registered there, and the error pins and the sticky flag change at k+2. The bench drives inputs at falling edges and samples at the falling edges after k+1, k+2 and k+3. This confirms the pin is quiet one cycle early, low in the due cycle and released one cycle later. The sticky-clear race is staged by raising the clear strobe in the cycle that ends at edge k+2.

// File: rtl/pcp_pkg.sv
package pcp_pkg;
  localparam int CMD_W        = 16;
  localparam int BIT_PERR_RSP = 6;
  localparam int BIT_SERR_EN  = 8;
  localparam int BIT_FBB_EN   = 9;
  // plain read/write bits: 0-4, 6, 8
  localparam logic [CMD_W-1:0] CMD_RW_MASK = 16'h015F;

  typedef struct packed {
    logic addr;
    logic data;
  } phase_t;
endpackage

// File: rtl/pcp_par_calc.sv
module pcp_par_calc #(
  parameter int W = 36
) (
  input  logic [W-1:0] vec,
  output logic         odd
);
  localparam int HALF = W / 2;

  logic lo_odd, hi_odd;

  generate
    if (W > 8) begin : g_split
      assign lo_odd = ^vec[HALF-1:0];
      assign hi_odd = ^vec[W-1:HALF];
    end else begin : g_flat
      assign lo_odd = ^vec;
      assign hi_odd = 1'b0;
    end
  endgenerate

  assign odd = lo_odd ^ hi_odd;
endmodule

// File: rtl/pcp_cmd_reg.sv
module pcp_cmd_reg
  import pcp_pkg::*;
#(
  parameter int               W       = CMD_W,
  parameter logic [W-1:0]     RW_MASK = CMD_RW_MASK,
  parameter int               FBB_BIT = BIT_FBB_EN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         fbb_strap,
  output logic [W-1:0] rd_data
);
  localparam logic [W-1:0] PLAIN_MASK = RW_MASK & ~(W'(1) << FBB_BIT);

  logic [W-1:0] rw_q, rw_d;
  logic         fbb_q, fbb_d;
  logic         rw_ce, fbb_ce;

  assign rw_ce  = wr_en;
  assign fbb_ce = wr_en & fbb_strap;

  always_comb begin
    rw_d  = wdata & PLAIN_MASK;
    fbb_d = wdata[FBB_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rw_q <= '0;
    end else if (rw_ce) begin
      rw_q <= rw_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fbb_q <= 1'b0;
    end else if (fbb_ce) begin
      fbb_q <= fbb_d;
    end
  end

  always_comb begin
    rd_data          = rw_q;
    rd_data[FBB_BIT] = fbb_q & fbb_strap;
  end

  AST_FBB_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !fbb_strap) |=> $stable(fbb_q)) else $error("fbb bit changed without strap"); // R3

  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[15:10] == 6'b0 && rd_data[7] == 1'b0 && rd_data[5] == 1'b0))
    else $error("fixed-zero bit set after write"); // R2
endmodule

// File: rtl/pcp_par_check.sv
module pcp_par_check
  import pcp_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad,
  input  logic [CBE_W-1:0] cbe,
  input  logic             par,
  input  logic             addr_phase,
  input  logic             data_phase,
  input  logic             perr_rsp,
  input  logic             serr_en,
  input  logic             sts_wr,
  input  logic             sts_wdata,
  output logic             perr_n,
  output logic             serr_n,
  output logic             err_seen
);
  localparam int VEC_W = AD_W + CBE_W;

  logic   bus_odd;
  logic   s1_odd_q;
  phase_t s1_ph_q, s1_ph_d;
  logic   err_addr_q, err_addr_d;
  logic   err_data_q, err_data_d;
  logic   perr_n_d, serr_n_d;
  logic   seen_d;
  logic   s2_ce;

  pcp_par_calc #(.W(VEC_W)) u_calc (
    .vec ({ad, cbe}),
    .odd (bus_odd)
  );

  // stage 1: capture bus parity and phase kind
  always_comb begin
    s1_ph_d.addr = addr_phase;
    s1_ph_d.data = data_phase;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_odd_q <= 1'b0;
      s1_ph_q  <= '0;
    end else begin
      s1_odd_q <= bus_odd;
      s1_ph_q  <= s1_ph_d;
    end
  end

  // stage 2: compare with the late parity line
  assign s2_ce = 1'b1;

  always_comb begin
    err_addr_d = s1_ph_q.addr & (s1_odd_q ^ par);
    err_data_d = s1_ph_q.data & (s1_odd_q ^ par);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_addr_q <= 1'b0;
      err_data_q <= 1'b0;
    end else if (s2_ce) begin
      err_addr_q <= err_addr_d;
      err_data_q <= err_data_d;
    end
  end

  // stage 3: pins and sticky flag
  always_comb begin
    perr_n_d = ~(err_data_q & perr_rsp);
    serr_n_d = ~(err_addr_q & serr_en & perr_rsp);
    seen_d   = err_seen;
    if (sts_wr && sts_wdata) seen_d = 1'b0;
    if (err_addr_q || err_data_q) seen_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perr_n   <= 1'b1;
      serr_n   <= 1'b1;
      err_seen <= 1'b0;
    end else begin
      perr_n   <= perr_n_d;
      serr_n   <= serr_n_d;
      err_seen <= seen_d;
    end
  end

  AST_PERR_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |-> $past(perr_rsp)) else $error("perr without response enable"); // R5

  AST_PERR_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |-> $past(data_phase, 3)) else $error("perr not traced to a data phase"); // R5

  AST_SERR_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n |-> ($past(serr_en) && $past(perr_rsp))) else $error("serr without enables"); // R6

  AST_SERR_FROM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n |-> $past(addr_phase, 3)) else $error("serr not traced to an address phase"); // R6

  AST_STICKY_WITH_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!perr_n || !serr_n) |-> err_seen) else $error("pin pulse without sticky flag"); // R7
endmodule

// File: rtl/pci_cmd_parity.sv
module pci_cmd_parity
  import pcp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CMD_W-1:0]  cfg_wdata,
  output logic [CMD_W-1:0]  cfg_rdata,
  input  logic              fbb_strap,
  input  logic [31:0]       ad,
  input  logic [3:0]        cbe,
  input  logic              par,
  input  logic              addr_phase,
  input  logic              data_phase,
  output logic              perr_n,
  output logic              serr_n,
  input  logic              sts_wr,
  input  logic              sts_wdata,
  output logic              par_err_seen
);
  logic [CMD_W-1:0] cmd;

  pcp_cmd_reg #(
    .W       (CMD_W),
    .RW_MASK (CMD_RW_MASK),
    .FBB_BIT (BIT_FBB_EN)
  ) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr),
    .wdata     (cfg_wdata),
    .fbb_strap (fbb_strap),
    .rd_data   (cmd)
  );

  pcp_par_check #(
    .AD_W  (32),
    .CBE_W (4)
  ) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ad         (ad),
    .cbe        (cbe),
    .par        (par),
    .addr_phase (addr_phase),
    .data_phase (data_phase),
    .perr_rsp   (cmd[BIT_PERR_RSP]),
    .serr_en    (cmd[BIT_SERR_EN]),
    .sts_wr     (sts_wr),
    .sts_wdata  (sts_wdata),
    .perr_n     (perr_n),
    .serr_n     (serr_n),
    .err_seen   (par_err_seen)
  );

  assign cfg_rdata = cmd;

  AST_PINS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_phase && data_phase) |-> 1'b1 ##0 !(!perr_n && !serr_n && $past(!(addr_phase && data_phase), 3)))
    else $error("both error pins from one phase"); // R6
endmodule

// File: tb/tb_pci_cmd_parity.sv
module tb_pci_cmd_parity;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [15:0] cfg_wdata;
  logic [15:0] cfg_rdata;
  logic        fbb_strap;
  logic [31:0] ad;
  logic [3:0]  cbe;
  logic        par;
  logic        addr_phase;
  logic        data_phase;
  logic        perr_n;
  logic        serr_n;
  logic        sts_wr;
  logic        sts_wdata;
  logic        par_err_seen;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_cmd_parity dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .fbb_strap(fbb_strap), .ad(ad), .cbe(cbe),
    .par(par), .addr_phase(addr_phase), .data_phase(data_phase),
    .perr_n(perr_n), .serr_n(serr_n), .sts_wr(sts_wr),
    .sts_wdata(sts_wdata), .par_err_seen(par_err_seen)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_cmd(input logic [15:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  // One bus phase at edge k; par at k+1; observe after k+1, k+2, k+3.
  task automatic bus_phase(input string tag, input bit is_addr, input logic [31:0] a,
                           input logic [3:0] c, input bit bad,
                           input bit exp_perr, input bit exp_serr, input bit exp_seen,
                           input bit clr_race);
    @(negedge clk);
    ad = a; cbe = c; addr_phase = is_addr; data_phase = !is_addr;
    @(negedge clk);
    addr_phase = 1'b0; data_phase = 1'b0;
    par = (^{a, c}) ^ bad;
    ad = ~a; cbe = ~c;
    @(negedge clk);
    chk({tag, " early perr_n"}, perr_n, 1'b1);
    chk({tag, " early serr_n"}, serr_n, 1'b1);
    if (clr_race) begin sts_wr = 1'b1; sts_wdata = 1'b1; end
    @(negedge clk);
    sts_wr = 1'b0; sts_wdata = 1'b0;
    chk({tag, " due perr_n"}, perr_n, !exp_perr);
    chk({tag, " due serr_n"}, serr_n, !exp_serr);
    chk({tag, " sticky"}, par_err_seen, exp_seen);
    @(negedge clk);
    chk({tag, " release perr_n"}, perr_n, 1'b1);
    chk({tag, " release serr_n"}, serr_n, 1'b1);
  endtask

  task automatic clear_sticky(input string tag, input logic v, input logic exp);
    @(negedge clk); sts_wr = 1'b1; sts_wdata = v;
    @(negedge clk); sts_wr = 1'b0; sts_wdata = 1'b0;
    chk(tag, par_err_seen, exp);
  endtask

  task automatic t_reset;
    chk("R1 reset cmd", cfg_rdata, 16'h0000);
    chk("R1 reset perr_n", perr_n, 1'b1);
    chk("R1 reset serr_n", serr_n, 1'b1);
    chk("R1 reset sticky", par_err_seen, 1'b0);
  endtask

  task automatic t_cmd_bits;
    fbb_strap = 1'b0;
    wr_cmd(16'hFFFF);
    chk("R2 all-ones write, strap off", cfg_rdata, 16'h015F);
    wr_cmd(16'h00A0);
    chk("R2 fixed bits 7 and 5 ignored", cfg_rdata, 16'h0000);
    wr_cmd(16'h0115);
    chk("R2 mixed pattern", cfg_rdata, 16'h0115);
  endtask

  task automatic t_fbb;
    fbb_strap = 1'b1;
    wr_cmd(16'hFFFF);
    chk("R3 strap on sets bit 9", cfg_rdata, 16'h035F);
    wr_cmd(16'h0040);
    chk("R3 strap on clears bit 9", cfg_rdata, 16'h0040);
    wr_cmd(16'h0200);
    fbb_strap = 1'b0;
    #1;
    chk("R3 strap off masks bit 9", cfg_rdata, 16'h0000);
    wr_cmd(16'h0000);
    fbb_strap = 1'b1;
    #1;
    chk("R3 write ignored while strap off", cfg_rdata, 16'h0200);
    fbb_strap = 1'b0;
  endtask

  task automatic t_good_parity;
    wr_cmd(16'h0140);
    bus_phase("R4 good data parity", 1'b0, 32'hDEADBEEF, 4'h6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    bus_phase("R4 good addr parity", 1'b1, 32'h00000001, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_data_err;
    wr_cmd(16'h0040);
    bus_phase("R5 data error, response on", 1'b0, 32'h12345678, 4'h3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    clear_sticky("R7 clear with 1", 1'b1, 1'b0);
    wr_cmd(16'h0100);
    bus_phase("R5 data error, response off", 1'b0, 32'hFFFFFFFF, 4'h0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    clear_sticky("R7 write 0 keeps flag", 1'b0, 1'b1);
    clear_sticky("R7 clear again", 1'b1, 1'b0);
  endtask

  task automatic t_addr_err;
    wr_cmd(16'h0140);
    bus_phase("R6 addr error, both enables", 1'b1, 32'hA5A5A5A5, 4'hC, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    clear_sticky("R7 clear after addr error", 1'b1, 1'b0);
    wr_cmd(16'h0100);
    bus_phase("R6 addr error, only bit 8", 1'b1, 32'h0F0F0F0F, 4'h1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    clear_sticky("R7 clear", 1'b1, 1'b0);
    wr_cmd(16'h0040);
    bus_phase("R6 addr error, only bit 6", 1'b1, 32'h80000000, 4'h8, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    clear_sticky("R7 clear", 1'b1, 1'b0);
    wr_cmd(16'h0140);
    bus_phase("R6 data error never on serr", 1'b0, 32'h00FF00FF, 4'h2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    clear_sticky("R7 clear", 1'b1, 1'b0);
  endtask

  task automatic t_sticky_race;
    wr_cmd(16'h0000);
    bus_phase("R7 set wins over clear", 1'b0, 32'h13579BDF, 4'h5, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    clear_sticky("R7 final clear", 1'b1, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0; fbb_strap = 1'b0;
    ad = '0; cbe = '0; par = 1'b0; addr_phase = 1'b0; data_phase = 1'b0;
    sts_wr = 1'b0; sts_wdata = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cmd_bits();
    t_fbb();
    t_good_parity();
    t_data_err();
    t_addr_err();
    t_sticky_race();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule